// File: doc/BRIEF.md
# Delayed and Combined Event Generator

This block sits behind the compare stages of a timer. It takes one single-cycle event pulse per channel and produces a delayed copy of each. All channels share one 4-bit delay code. The code selects a cycle count from a fixed, uneven table, so the same delay applies to every channel. Each delayed copy is a single-cycle pulse.

A second output merges the delayed pulses of the channels whose bit is set in a combine mask. The combined output is a plain OR, so it is high in every cycle that a selected channel fires. Each channel keeps its own down-counter, which loads when an event arrives. Because of that, a new event on a busy channel restarts its wait. The block stores no event flags and contains no compare logic.

Top module: `evdly_core`

## Requirements
- R1: Delay code c (1..13) makes the delayed pulse appear exactly N cycles after the cycle holding the input event. N is 1, 2, 4, 8, 16, 32, 48, 64, 80, 96, 112, 128 and 144 for codes 1 to 13.
- R2: With code 0, the delayed output goes high in the same cycle as the input event, with no register stage between them.
- R3: Codes 14 and 15 are out of range and behave exactly like code 13 (144 cycles).
- R4: Each input event produces one delayed pulse, one cycle wide, unless a later event on that channel replaces it.
- R5: An event that arrives while a delay is pending on its channel restarts the wait from the full count, so only one pulse follows, N cycles after the newer event. An event that lands in the very cycle the previous pulse leaves does not suppress that pulse; it starts a new wait.
- R6: The delay is captured when the event arrives. A later change of the code does not alter a wait that is already running.
- R7: An event with code 0 passes straight through and cancels any delay still pending on that channel.
- R8: The combined output is high in a cycle exactly when some channel i with mask bit i set (bit 0 = channel 0, bit 1 = channel 1, bit 2 = channel 2) has its delayed output high in that cycle.
- R9: With an all-zero mask, the combined output never goes high.
- R10: The channels are independent. Events on different channels at different times each give their own pulse, timed from the shared code.
- R11: After reset, no delay is pending and no output pulses without a new input event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears all pending delays |
| ev_i | input | 3 | Single-cycle input event per channel |
| delay_code_i | input | 4 | Shared delay code |
| comb_mask_i | input | 3 | Channel select for the combined output |
| dly_o | output | 3 | Delayed event pulse per channel |
| comb_o | output | 1 | OR of the delayed pulses of the selected channels |

## Verification
Two functions can fall in the same cycle: a channel's pending delay expiring, and a new event arriving on that same channel. The bench provokes this by firing a second event exactly N cycles after the first. It expects the first pulse still to appear at N and a second pulse at 2N. A code-0 event arriving during a running wait is the second overlap; here the bench expects the pulse to pass through at once and nothing to follow.

// File: rtl/evdly_pkg.sv
package evdly_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned MAX_CODE = 13;
  localparam int unsigned CNT_W    = 8;

  // Cycle count for a delay code.
  // Codes 1-2 are linear, 3-6 double from 4, and 7-13 step by 16 from 48.
  // Codes above MAX_CODE are clamped to MAX_CODE.
  function automatic logic [CNT_W-1:0] code_to_cycles(input logic [CODE_W-1:0] c);
    int unsigned k;
    int unsigned n;
    k = (int'(c) > int'(MAX_CODE)) ? MAX_CODE : int'(c);
    if (k < 3)      n = k;
    else if (k < 7) n = 1 << (k - 1);
    else            n = 16 * (k - 4);
    return CNT_W'(n);
  endfunction
endpackage

// File: rtl/evdly_code_map.sv
module evdly_code_map
  import evdly_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  cycles_o,
  output logic              pass_o
);
  always_comb begin
    cycles_o = code_to_cycles(code_i);
    pass_o   = (code_i == '0);
  end
endmodule

// File: rtl/evdly_lane.sv
module evdly_lane #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             pass_i,
  output logic             expire_o,
  output logic             pend_o,
  output logic             dly_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // The counter loads on an event, which restarts any wait in progress.
  // A load of zero (code 0) cancels the pending wait.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ev_i)           cnt_q <= load_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign expire_o = (cnt_q == ONE);
  assign pend_o   = (cnt_q != '0);
  assign dly_o    = (ev_i & pass_i) | expire_o;
endmodule

// File: rtl/evdly_merge.sv
module evdly_merge #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic [NUM_CH-1:0] dly_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              comb_o
);
  assign comb_o = |(dly_i & mask_i);
endmodule

// File: rtl/evdly_core.sv
module evdly_core
  import evdly_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_i,
  input  logic [CODE_W-1:0] delay_code_i,
  input  logic [NUM_CH-1:0] comb_mask_i,
  output logic [NUM_CH-1:0] dly_o,
  output logic              comb_o
);
  logic [CNT_W-1:0]  load_cycles;
  logic              code_pass;
  logic [NUM_CH-1:0] lane_expire;
  logic [NUM_CH-1:0] lane_pend;

  evdly_code_map u_map (
    .code_i   (delay_code_i),
    .cycles_o (load_cycles),
    .pass_o   (code_pass)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    evdly_lane #(.CNT_W(CNT_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev_i[g]),
      .load_i   (load_cycles),
      .pass_i   (code_pass),
      .expire_o (lane_expire[g]),
      .pend_o   (lane_pend[g]),
      .dly_o    (dly_o[g])
    );
  end

  evdly_merge #(.NUM_CH(NUM_CH)) u_merge (
    .dly_i  (dly_o),
    .mask_i (comb_mask_i),
    .comb_o (comb_o)
  );
endmodule

// File: rtl/evdly_core_chk.sv
module evdly_core_chk
  import evdly_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ev_i,
  input logic [CODE_W-1:0] delay_code_i,
  input logic [NUM_CH-1:0] comb_mask_i,
  input logic [NUM_CH-1:0] dly_o,
  input logic              comb_o,
  input logic [NUM_CH-1:0] lane_pend
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // R2: code 0 passes an event straight through
    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[g] && delay_code_i == '0) |-> dly_o[g]);
    // R1: code 1 gives the pulse one cycle later
    p_delay_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i[g] && delay_code_i == 4'd1) |=> dly_o[g]);
    // R4: a pulse with no new event behind it lasts a single cycle
    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_o[g] && !ev_i[g]) |=> (!dly_o[g] || (ev_i[g] && delay_code_i == '0)));
    // R11: with nothing pending and no pass-through, the output stays low
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!lane_pend[g] && !ev_i[g]) |-> !dly_o[g]);
  end

  // R9: empty mask keeps the combined output low
  p_mask_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_mask_i == '0) |-> !comb_o);
  // R8: a selected delayed pulse shows on the combined output
  p_comb_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dly_o & comb_mask_i)) |-> comb_o);
  // R8: the combined output needs a selected source
  p_comb_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    comb_o |-> (|(dly_o & comb_mask_i)));
endmodule

bind evdly_core evdly_core_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_i         (ev_i),
  .delay_code_i (delay_code_i),
  .comb_mask_i  (comb_mask_i),
  .dly_o        (dly_o),
  .comb_o       (comb_o),
  .lane_pend    (lane_pend)
);

// File: tb/evdly_core_test.sv
module evdly_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ev_i = '0;
  logic [3:0] delay_code_i = '0;
  logic [2:0] comb_mask_i = '0;
  logic [2:0] dly_o;
  logic       comb_o;

  evdly_core uut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .delay_code_i(delay_code_i),
    .comb_mask_i(comb_mask_i), .dly_o(dly_o), .comb_o(comb_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hits [3];
  int first_hit [3];
  int last_hit [3];
  int comb_hits;

  function automatic int expect_cycles(input int code);
    if (code == 0) return 0;
    if (code <= 2) return code;
    if (code <= 6) return 2 ** (code - 1);
    if (code <= 13) return 48 + 16 * (code - 7);
    return 144;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    for (int i = 0; i < 3; i++) begin
      hits[i] = 0; first_hit[i] = -1; last_hit[i] = -1;
    end
    comb_hits = 0;
  endtask

  // One clock cycle: drive after the falling edge, sample shortly after.
  task automatic step(input logic [2:0] ev, input logic [3:0] code);
    @(negedge clk);
    ev_i = ev;
    delay_code_i = code;
    #2;
    cyc++;
    for (int i = 0; i < 3; i++) begin
      if (dly_o[i]) begin
        hits[i]++;
        if (first_hit[i] < 0) first_hit[i] = cyc;
        last_hit[i] = cyc;
      end
    end
    if (comb_o) comb_hits++;
  endtask

  task automatic idle(input int n, input logic [3:0] code);
    for (int k = 0; k < n; k++) step(3'b000, code);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    int t1;
    clear_log();
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R11: quiet after reset
    comb_mask_i = 3'b111;
    idle(6, 4'd3);
    check("R11 pulses after reset", hits[0] + hits[1] + hits[2], 0);
    check("R11 combined after reset", comb_hits, 0);

    // R1 R2 R3 R4: every code on every channel
    for (int code = 0; code < 16; code++) begin
      for (int ch = 0; ch < 3; ch++) begin
        clear_log();
        step(3'b001 << ch, 4'(code));
        t0 = cyc;
        idle(150, 4'(code));
        if (code == 0) check("R2 same-cycle offset", first_hit[ch] - t0, 0);
        else if (code > 13) check("R3 clamped offset", first_hit[ch] - t0, 144);
        else check("R1 offset", first_hit[ch] - t0, expect_cycles(code));
        check("R4 single pulse", hits[ch], 1);
      end
    end

    // R8 R9: mask sweep, single channel and all channels
    for (int m = 0; m < 8; m++) begin
      comb_mask_i = 3'(m);
      for (int ch = 0; ch < 3; ch++) begin
        clear_log();
        step(3'b001 << ch, 4'd1);
        idle(3, 4'd1);
        if (m == 0) check("R9 empty mask", comb_hits, 0);
        else check("R8 masked channel", comb_hits, (m >> ch) & 1);
      end
      clear_log();
      step(3'b111, 4'd2);
      idle(4, 4'd2);
      check("R8 all channels", comb_hits, (m != 0) ? 1 : 0);
    end
    comb_mask_i = 3'b111;

    // R5: restart while pending (code 5 = 16 cycles)
    clear_log();
    step(3'b001, 4'd5);
    idle(9, 4'd5);
    step(3'b001, 4'd5);
    t1 = cyc;
    idle(40, 4'd5);
    check("R5 restart pulse count", hits[0], 1);
    check("R5 restart offset", first_hit[0] - t1, 16);

    // R5: new event in the cycle the pulse leaves (code 4 = 8 cycles)
    clear_log();
    step(3'b010, 4'd4);
    t0 = cyc;
    idle(7, 4'd4);
    step(3'b010, 4'd4);
    idle(20, 4'd4);
    check("R5 collision pulse count", hits[1], 2);
    check("R5 collision first", first_hit[1] - t0, 8);
    check("R5 collision second", last_hit[1] - t0, 16);

    // R6: code change after the event leaves the wait alone
    clear_log();
    step(3'b100, 4'd5);
    t0 = cyc;
    idle(30, 4'd1);
    check("R6 latched delay", first_hit[2] - t0, 16);
    check("R6 pulse count", hits[2], 1);

    // R7: code-0 event cancels a pending wait
    clear_log();
    step(3'b001, 4'd6);
    idle(3, 4'd6);
    step(3'b001, 4'd0);
    t1 = cyc;
    idle(50, 4'd6);
    check("R7 pass-through", first_hit[0] - t1, 0);
    check("R7 cancelled", hits[0], 1);

    // R10: staggered channels under shared code 3 (4 cycles)
    clear_log();
    step(3'b001, 4'd3);
    t0 = cyc;
    step(3'b000, 4'd3);
    step(3'b100, 4'd3);
    t1 = cyc;
    idle(10, 4'd3);
    check("R10 channel 0", first_hit[0] - t0, 4);
    check("R10 channel 2", first_hit[2] - t1, 4);
    check("R10 channel 1 silent", hits[1], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule